// File: doc/BRIEF.md
# Pipelined Histogram Bin Updater

This block counts how often each pixel value occurs in a pixel stream. The pixel value is used directly as the address of a counter in a dual-port bin memory. Every accepted pixel starts a four-step update: the bin is read, its value is captured in a register, the captured value is incremented, and the result is written back. Each step takes one clock. The steps of successive pixels overlap, so the block accepts one pixel on every clock and never stalls the stream during normal operation.

The update has no forwarding path and does not detect hazards. The caller must keep two equal pixel values at least four clock cycles apart; otherwise the second update reads a stale count. A clear control zeroes every bin, one address per clock, after the updates in flight have finished. Reset starts the same clear. A separate request/response port returns the count held by any single bin.

Both streams use valid/ready. A pixel is taken on a clock edge where `pix_valid` and `pix_ready` are both high. `pix_ready` drops only while a clear is in progress. A read request is taken when `rq_valid` and `rq_ready` are both high. The response is then held on `rsp_valid`/`rsp_count` until the consumer raises `rsp_ready`. Only one read can be outstanding at a time.

Top module: `hist_bin_updater`

## Requirements
- R1: After reset every bin reads zero. `pix_ready` stays low from reset until the first one-cycle `clr_done` pulse, which follows within the bin count plus four cycles.
- R2: Each accepted pixel adds one to the bin whose address equals the pixel value. The write-back happens on the fourth clock edge after acceptance. Counts are exact whenever equal pixel values are accepted at least four cycles apart, and four cycles apart is allowed.
- R3: Outside a clear, `pix_ready` is high on every cycle, so a pixel can be accepted on every clock.
- R4: A `clr_start` pulse while idle first lets every update in flight finish. The block then writes zero to every bin, one per cycle. It then raises `clr_done` for exactly one cycle. `pix_ready` is low from the cycle after `clr_start` until `clr_done`.
- R5: A pixel presented while `pix_ready` is low is not counted. A `clr_start` that arrives during a clear is ignored and produces no second `clr_done`.
- R6: A bin that holds the all-ones value of `CNT_W` bits keeps that value when it is hit again. It does not wrap.
- R7: `rq_ready` is high only while `pix_valid` is low, no clear is running, and no read is outstanding. The bin memory read port serves either a pixel update or a read request, never both in the same cycle.
- R8: Once `rsp_valid` is high, it and `rsp_count` hold their values until a cycle with `rsp_ready` high. The count returned is that of the bin at `rq_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; starts a full clear |
| pix_valid | input | 1 | Pixel stream valid |
| pix_ready | output | 1 | Pixel stream ready; low only during a clear |
| pix_data | input | PIX_W | Pixel value, used as the bin address |
| clr_start | input | 1 | Pulse to zero all bins |
| clr_done | output | 1 | One-cycle pulse when the clear has finished |
| rq_valid | input | 1 | Read request valid |
| rq_ready | output | 1 | Read request ready |
| rq_addr | input | PIX_W | Bin to read |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_count | output | CNT_W | Count of the requested bin |

## Verification
The assertions check on every cycle that:
- each accepted pixel produces exactly one write-back four cycles later, and no write-back appears without one;
- a write-back never carries zero, which is what a wrap would produce;
- the clear walker writes only when no update is in flight;
- the memory read port has at most one user;
- a held response does not change;
- `clr_done` lasts exactly one cycle.

Whether the counts are right, including at the four-cycle repeat boundary and at saturation, can only be seen in the bench's scenarios. The same holds for ignoring pixels and repeated clear requests during a clear, and for all bins being zero after reset. The bench reads every bin back and compares it with its own model.

// File: rtl/hist_pkg.sv
package hist_pkg;
  // Number of one-cycle steps in the read-modify-write of one pixel.
  localparam int RMW_STAGES = 4;
  // Stage indices within the update pipeline.
  localparam int ST_RD = 0;
  localparam int ST_LD = 1;
  localparam int ST_AD = 2;
  localparam int ST_WR = 3;

  typedef enum logic [1:0] {
    CLR_IDLE  = 2'd0,
    CLR_DRAIN = 2'd1,
    CLR_WALK  = 2'd2
  } clr_state_e;
endpackage

// File: rtl/hist_bin_ram.sv
// Bin memory: one synchronous read port, one write port.
// A read and a write to the same address on the same edge return the old data.
module hist_bin_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end
endmodule

// File: rtl/hist_rmw_pipe.sv
// Four overlapping one-cycle steps: read, latch, increment, write back.
module hist_rmw_pipe
  import hist_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,      // pixel accepted this cycle
  input  logic [PIX_W-1:0] take_pix,
  input  logic [CNT_W-1:0] ram_q,     // memory data, valid in the latch step
  output logic             rd_act,    // read step owns the memory read port
  output logic [PIX_W-1:0] rd_addr,
  output logic             wb_en,
  output logic [PIX_W-1:0] wb_addr,
  output logic [CNT_W-1:0] wb_data,
  output logic             busy
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             stg_v [RMW_STAGES];
  logic [PIX_W-1:0] stg_a [RMW_STAGES];
  logic [CNT_W-1:0] held_cnt;
  logic [CNT_W-1:0] next_cnt;

  // First step is loaded from the accepted pixel.
  always_ff @(posedge clk) begin
    if (rst) stg_v[0] <= 1'b0;
    else     stg_v[0] <= take;
  end
  always_ff @(posedge clk) begin
    if (take) stg_a[0] <= take_pix;
  end

  // The later steps follow the one before them on every clock.
  for (genvar k = 1; k < RMW_STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg_v[k] <= 1'b0;
      else     stg_v[k] <= stg_v[k-1];
    end
    always_ff @(posedge clk) begin
      stg_a[k] <= stg_a[k-1];
    end
  end

  // Latch step: capture the count that the memory returned.
  always_ff @(posedge clk) begin
    if (stg_v[ST_LD]) held_cnt <= ram_q;
  end

  // Increment step: add one, stopping at the all-ones value.
  always_ff @(posedge clk) begin
    if (stg_v[ST_AD]) next_cnt <= (held_cnt == CNT_MAX) ? CNT_MAX : held_cnt + 1'b1;
  end

  assign rd_act  = stg_v[ST_RD];
  assign rd_addr = stg_a[ST_RD];
  assign wb_en   = stg_v[ST_WR];
  assign wb_addr = stg_a[ST_WR];
  assign wb_data = next_cnt;

  always_comb begin
    busy = 1'b0;
    for (int k = 0; k < RMW_STAGES; k++) busy = busy | stg_v[k];
  end
endmodule

// File: rtl/hist_clear_walker.sv
// Waits for the update steps to drain, then zeroes every bin, one per cycle.
module hist_clear_walker
  import hist_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             pipe_busy,
  output logic             wipe_en,
  output logic [PIX_W-1:0] wipe_addr,
  output logic             active,
  output logic             done
);
  localparam logic [PIX_W-1:0] LAST_BIN = {PIX_W{1'b1}};

  clr_state_e       state;
  logic [PIX_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CLR_WALK;           // reset clears the memory too
      ptr   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        CLR_IDLE: begin
          if (start) state <= CLR_DRAIN;
        end
        CLR_DRAIN: begin
          if (!pipe_busy) begin
            state <= CLR_WALK;
            ptr   <= '0;
          end
        end
        CLR_WALK: begin
          if (ptr == LAST_BIN) begin
            state <= CLR_IDLE;
            done  <= 1'b1;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
        default: state <= CLR_IDLE;
      endcase
    end
  end

  assign wipe_en   = (state == CLR_WALK);
  assign wipe_addr = ptr;
  assign active    = (state != CLR_IDLE);
endmodule

// File: rtl/hist_readout.sv
// Single-outstanding read of one bin count, valid/ready on both sides.
module hist_readout #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             port_free,  // no pixel and no clear this cycle
  input  logic             rq_valid,
  output logic             rq_ready,
  input  logic [PIX_W-1:0] rq_addr,
  input  logic [CNT_W-1:0] ram_q,
  output logic             own,        // owns the memory read port
  output logic [PIX_W-1:0] own_addr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [CNT_W-1:0] rsp_count
);
  logic wait_q;   // memory data arrives this cycle

  assign rq_ready = port_free && !own && !wait_q && !rsp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      own       <= 1'b0;
      wait_q    <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      own    <= rq_valid && rq_ready;
      wait_q <= own;
      if (wait_q)                     rsp_valid <= 1'b1;
      else if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rq_valid && rq_ready) own_addr <= rq_addr;
    if (wait_q)               rsp_count <= ram_q;
  end
endmodule

// File: rtl/hist_bin_updater.sv
module hist_bin_updater #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             clr_start,
  output logic             clr_done,
  input  logic             rq_valid,
  output logic             rq_ready,
  input  logic [PIX_W-1:0] rq_addr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [CNT_W-1:0] rsp_count
);
  logic             pix_take;
  logic             pipe_rd_act;
  logic [PIX_W-1:0] pipe_rd_addr;
  logic             pipe_we;
  logic [PIX_W-1:0] pipe_waddr;
  logic [CNT_W-1:0] pipe_wdata;
  logic             pipe_busy;
  logic             walk_we;
  logic [PIX_W-1:0] walk_addr;
  logic             clr_busy;
  logic             rd_own;
  logic [PIX_W-1:0] rd_own_addr;
  logic [PIX_W-1:0] mem_raddr;
  logic [CNT_W-1:0] mem_q;
  logic             mem_we;
  logic [PIX_W-1:0] mem_waddr;
  logic [CNT_W-1:0] mem_wdata;

  assign pix_ready = !clr_busy;
  assign pix_take  = pix_valid && pix_ready;

  hist_rmw_pipe #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .take     (pix_take),
    .take_pix (pix_data),
    .ram_q    (mem_q),
    .rd_act   (pipe_rd_act),
    .rd_addr  (pipe_rd_addr),
    .wb_en    (pipe_we),
    .wb_addr  (pipe_waddr),
    .wb_data  (pipe_wdata),
    .busy     (pipe_busy)
  );

  hist_clear_walker #(.PIX_W(PIX_W)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .start     (clr_start),
    .pipe_busy (pipe_busy),
    .wipe_en   (walk_we),
    .wipe_addr (walk_addr),
    .active    (clr_busy),
    .done      (clr_done)
  );

  hist_readout #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .port_free (!pix_valid && !clr_busy),
    .rq_valid  (rq_valid),
    .rq_ready  (rq_ready),
    .rq_addr   (rq_addr),
    .ram_q     (mem_q),
    .own       (rd_own),
    .own_addr  (rd_own_addr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_count (rsp_count)
  );

  // Read port: a read request and a pixel read step never coincide.
  assign mem_raddr = rd_own ? rd_own_addr : pipe_rd_addr;
  // Write port: the walker writes only after the pipeline has drained.
  assign mem_we    = walk_we || pipe_we;
  assign mem_waddr = walk_we ? walk_addr : pipe_waddr;
  assign mem_wdata = walk_we ? '0 : pipe_wdata;

  hist_bin_ram #(.AW(PIX_W), .DW(CNT_W)) u_ram (
    .clk     (clk),
    .rd_addr (mem_raddr),
    .rd_data (mem_q),
    .wr_en   (mem_we),
    .wr_addr (mem_waddr),
    .wr_data (mem_wdata)
  );
endmodule

// File: rtl/hist_bin_updater_sva.sv
module hist_bin_updater_sva #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_valid,
  input logic             pix_ready,
  input logic             clr_done,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [CNT_W-1:0] rsp_count,
  input logic             pipe_we,
  input logic [CNT_W-1:0] pipe_wdata,
  input logic             pipe_busy,
  input logic             walk_we,
  input logic             pipe_rd_act,
  input logic             rd_own
);
  // R2: every accepted pixel is written back four edges later
  p_wb_after_take_r2: assert property (@(posedge clk) disable iff (rst)
    $past(pix_valid && pix_ready, 4) |-> pipe_we);

  // R2: no write-back without a pixel accepted four edges earlier
  p_wb_has_source_r2: assert property (@(posedge clk) disable iff (rst)
    pipe_we |-> $past(pix_valid && pix_ready, 4));

  // R6: a saturating count never wraps to zero
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    pipe_we |-> (pipe_wdata != '0));

  // R4: the clear writes only into a drained pipeline
  p_wipe_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    walk_we |-> !pipe_busy);

  // R4: the done flag is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    clr_done |=> !clr_done);

  // R7: the memory read port has one user at a time
  p_port_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(pipe_rd_act && rd_own));

  // R8: a held response does not change
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_count)));
endmodule

bind hist_bin_updater hist_bin_updater_sva #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .pix_valid   (pix_valid),
  .pix_ready   (pix_ready),
  .clr_done    (clr_done),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_count   (rsp_count),
  .pipe_we     (pipe_we),
  .pipe_wdata  (pipe_wdata),
  .pipe_busy   (pipe_busy),
  .walk_we     (walk_we),
  .pipe_rd_act (pipe_rd_act),
  .rd_own      (rd_own)
);

// File: tb/hist_bin_updater_test.sv
`timescale 1ns/1ps
module hist_bin_updater_test;
  localparam int PW   = 4;
  localparam int CW   = 4;
  localparam int NB   = 1 << PW;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pix_valid = 1'b0;
  logic          pix_ready;
  logic [PW-1:0] pix_data = '0;
  logic          clr_start = 1'b0;
  logic          clr_done;
  logic          rq_valid = 1'b0;
  logic          rq_ready;
  logic [PW-1:0] rq_addr = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [CW-1:0] rsp_count;

  int checks = 0;
  int errors = 0;
  int model [NB];
  int exp_q [$];
  string tag_q [$];

  always #2.5 clk = ~clk;   // 200 MHz

  hist_bin_updater #(.PIX_W(PW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .clr_start(clr_start), .clr_done(clr_done),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_count(rsp_count)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected counts as responses are consumed.
  always @(negedge clk) begin
    if (!rst && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected response", int'(rsp_count), -1);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(rsp_count) == e, t, int'(rsp_count), e);
      end
    end
  end

  // Driver: issue a read and push the expected count.
  task automatic read_bin(input int a, input string tag);
    @(posedge clk); #1;
    rq_valid = 1'b1;
    rq_addr  = a[PW-1:0];
    exp_q.push_back(model[a]);
    tag_q.push_back(tag);
    while (!rq_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    rq_valid = 1'b0;
  endtask

  task automatic drain_reads();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < NB; a++) read_bin(a, tag);
    drain_reads();
  endtask

  // Returns 1 when the pixel was accepted.
  task automatic send_pixel(input int v, output bit took);
    @(posedge clk); #1;
    pix_valid = 1'b1;
    pix_data  = v[PW-1:0];
    took = pix_ready;
    if (took) model[v] = (model[v] == CMAX) ? CMAX : model[v] + 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; pix_valid = 1'b0; end
  endtask

  task automatic pulse_clear();
    @(posedge clk); #1;
    pix_valid = 1'b0;
    clr_start = 1'b1;
    @(posedge clk); #1;
    clr_start = 1'b0;
    for (int a = 0; a < NB; a++) model[a] = 0;
  endtask

  task automatic wait_done(output int cycles);
    cycles = 0;
    while (!clr_done && cycles < 4 * NB) begin @(negedge clk); cycles++; end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    int stalls;
    int dones;
    bit took;
    logic [CW-1:0] held;
    for (int a = 0; a < NB; a++) model[a] = 0;

    repeat (8) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: not ready while the reset clear runs
    check(pix_ready == 1'b0, "R1 pix_ready low after reset", int'(pix_ready), 0);
    wait_done(cyc);
    check(clr_done == 1'b1 && cyc <= NB + 4, "R1 clr_done after reset clear", cyc, NB);
    @(negedge clk);
    check(clr_done == 1'b0, "R4 clr_done one cycle", int'(clr_done), 0);
    // R3: ready again once idle
    check(pix_ready == 1'b1, "R3 pix_ready high when idle", int'(pix_ready), 1);
    read_all("R1 bin zero after reset");

    // R2/R3: back-to-back stream; consecutive four accepted values differ
    // in their top two bits, so equal values recur at four cycles or more.
    stalls = 0;
    for (int i = 0; i < 160; i++) begin
      send_pixel(((i % 4) << 2) | (((i * 7 + i / 4) >> 1) & 3), took);
      if (!took) stalls++;
      if (i % 37 == 36) idle(2);
    end
    idle(6);
    check(stalls == 0, "R3 no stall during stream", stalls, 0);
    read_all("R2 stream counts");

    // R2: single value every fourth cycle, the tightest legal spacing
    for (int i = 0; i < 5; i++) begin
      send_pixel(2, took);
      idle(3);
    end
    idle(4);
    read_bin(2, "R2 four-cycle repeat");
    drain_reads();

    // R7: request not taken while a pixel is valid
    @(posedge clk); #1;
    pix_valid = 1'b1;
    pix_data  = 4'd1;
    if (pix_ready) model[1] = model[1] + 1;
    rq_valid = 1'b1;
    rq_addr  = 4'd1;
    @(negedge clk);
    check(rq_ready == 1'b0, "R7 rq_ready low with pix_valid", int'(rq_ready), 0);
    @(posedge clk); #1;
    pix_valid = 1'b0;
    rq_valid  = 1'b0;
    idle(6);
    read_bin(1, "R7 count after pixel");
    drain_reads();

    // R8: response held under back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    read_bin(5, "R8 held response value");
    repeat (3) @(negedge clk);
    held = rsp_count;
    check(rsp_valid == 1'b1, "R8 rsp_valid held", int'(rsp_valid), 1);
    check(rq_ready == 1'b0, "R7 rq_ready low with response pending", int'(rq_ready), 0);
    repeat (3) @(negedge clk);
    check(rsp_count == held && rsp_valid, "R8 rsp_count stable", int'(rsp_count), int'(held));
    @(posedge clk); #1 rsp_ready = 1'b1;
    drain_reads();

    // R4/R5: clear with an update in flight, pixels and clr_start during it
    send_pixel(3, took);
    pulse_clear();
    stalls = 0;
    dones  = 0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      pix_valid = 1'b1;
      pix_data  = i[PW-1:0];
      if (pix_ready) stalls++;
      clr_start = (i == 4);
    end
    @(posedge clk); #1;
    pix_valid = 1'b0;
    clr_start = 1'b0;
    check(stalls == 0, "R4 pix_ready low during clear", stalls, 0);
    for (int i = 0; i < 3 * NB; i++) begin
      @(negedge clk);
      if (clr_done) dones++;
    end
    check(dones == 1, "R5 second clr_start ignored", dones, 1);
    read_all("R5 bins zero after clear");

    // R6: saturation at the all-ones count, and exactly reaching it
    for (int i = 0; i < CMAX + 5; i++) begin
      send_pixel(6, took);
      idle(3);
    end
    for (int i = 0; i < CMAX; i++) begin
      send_pixel(9, took);
      idle(3);
    end
    idle(6);
    read_bin(6, "R6 saturated bin");
    read_bin(9, "R6 bin at maximum");
    read_bin(0, "R6 neighbour untouched");
    drain_reads();
    check(model[6] == CMAX, "R6 model saturates", model[6], CMAX);

    repeat (4) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule